// File: doc/BRIEF.md
# Scoreboard Hazard Control Unit

This block is the central hazard controller of an in-order-issue, out-of-order-completion pipeline that has no operand bypassing and no register renaming. Decoded instructions arrive one per cycle on a valid/ready handshake. Each carries an operation class, a destination register and two source registers. The controller gives every accepted instruction its own functional unit. From then on it steps the instruction through three more phases: operand read, execution and result write. Each phase has its own grant or input.

There are five functional units: unit 0 is the integer unit, unit 1 the adder, units 2 and 3 the multipliers and unit 4 the divider. Their datapaths are outside the block. A unit starts computing when it sees its operand-read grant, and it returns a one-cycle completion pulse when its result is ready. The controller keeps a status entry for each unit and a table that records, for each register, which unit will write it next.

Structural and output (WAW) hazards are resolved at issue. True data (RAW) hazards are resolved at operand read, where an instruction waits until the register file holds its sources. Anti-dependences (WAR) are resolved at result write, where a finished unit is held back while an older instruction still has to read the old register value.

Top module: `sb_hazard_ctl`

## Requirements
- R1: After reset no unit is busy, `read_grant` and `wb_grant` are all zero, and `in_ready` is high for any class and destination.
- R2: An instruction is not accepted while every unit of its class is busy. Class encoding on `in_cls`: 0 integer, 1 add, 2 multiply, 3 divide. Once a unit of that class writes back, it can be accepted in the next cycle.
- R3: An instruction is not accepted while its destination register is the pending destination of an instruction that has issued but not yet written back.
- R4: Acceptance is in program order, at most one instruction per cycle. `issue_fu` names the unit allocated: integer 0, add 1, multiply the lowest free of 2 and 3, divide 4.
- R5: An instruction whose source has a pending producer is not granted its operand read until the cycle after that producer's write-back grant.
- R6: An instruction whose sources have no pending producer receives `read_grant` in the cycle after it is accepted. The grant lasts one cycle per instruction.
- R7: A unit receives `wb_grant` no earlier than the cycle after its `fu_done` pulse.
- R8: A finished unit is not granted write-back while an older instruction that is waiting to read operands still has an unread source equal to that unit's destination. It is granted in the cycle after that read.
- R9: At most one unit is granted write-back per cycle. Among eligible units the lowest index wins, and `wb_dst` gives the destination of the granted unit.
- R10: A write-back grant frees the unit and clears the pending status of its destination, so that an instruction writing the same register can be accepted in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Instruction can be accepted this cycle |
| in_cls | input | 2 | Operation class (0 int, 1 add, 2 mul, 3 div) |
| in_dst | input | 4 | Destination register |
| in_src1 | input | 4 | First source register |
| in_src2 | input | 4 | Second source register |
| issue_fu | output | 3 | Unit allocated to the offered instruction |
| read_grant | output | 5 | Per-unit operand-read grant |
| fu_done | input | 5 | Per-unit completion pulse |
| wb_grant | output | 5 | Per-unit write-back grant (one-hot or zero) |
| wb_dst | output | 4 | Destination register of the granted write-back |

## Verification
A corrupted unit entry or register-status entry shows up at the ports as a grant at the wrong cycle. An operand read can come too early, before its producer wrote. A write-back can overtake a pending reader. The handshake can stall on a register nobody writes, or a unit can never free. The stimulus builds dependence chains on a long divide, with known unit latencies, so that each of these errors moves a grant by at least one cycle against a precomputed cycle number. A scoreboard queue also checks the order of write-back destinations, which exposes wrong priority or a lost or duplicated write-back on the first grant that differs.

// File: rtl/sb_pkg.sv
package sb_pkg;

    localparam int NUM_FU = 5;
    localparam int FU_W   = $clog2(NUM_FU);
    localparam int NREG   = 16;
    localparam int REG_W  = $clog2(NREG);

    typedef logic [FU_W-1:0]  fu_idx_t;
    typedef logic [REG_W-1:0] reg_idx_t;

    typedef enum logic [1:0] {
        CLS_INT = 2'd0,
        CLS_ADD = 2'd1,
        CLS_MUL = 2'd2,
        CLS_DIV = 2'd3
    } op_cls_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_EXEC = 2'd2,
        ST_DONE = 2'd3
    } fu_stage_e;

    // producer tag: which unit will write a register
    typedef struct packed {
        logic    vld;
        fu_idx_t fu;
    } tag_t;

    typedef struct packed {
        reg_idx_t dst;
        reg_idx_t src1;
        reg_idx_t src2;
    } instr_regs_t;

    // full per-unit status
    typedef struct packed {
        fu_stage_e stage;
        reg_idx_t  fi;
        reg_idx_t  fj;
        reg_idx_t  fk;
        tag_t      qj;
        tag_t      qk;
        logic      rj;
        logic      rk;
    } fu_entry_t;

    // part of the status the write-back arbiter looks at
    typedef struct packed {
        fu_stage_e stage;
        reg_idx_t  fi;
        reg_idx_t  fj;
        reg_idx_t  fk;
        logic      rj;
        logic      rk;
    } fu_view_t;

    // class served by each unit index
    function automatic op_cls_e unit_class(input int idx);
        case (idx)
            0:       return CLS_INT;
            1:       return CLS_ADD;
            2, 3:    return CLS_MUL;
            default: return CLS_DIV;
        endcase
    endfunction

    // tag seen by a newly issued reader, with a same-cycle write-back removed
    function automatic tag_t resolve_tag(input tag_t t, input logic wb_fire,
                                         input fu_idx_t wb_fu);
        tag_t r;
        r = t;
        if (t.vld && wb_fire && (t.fu == wb_fu))
            r.vld = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/sb_issue_ctl.sv
module sb_issue_ctl
    import sb_pkg::*;
(
    input  logic              in_valid,
    input  op_cls_e           cls,
    input  reg_idx_t          dst,
    input  logic [NUM_FU-1:0] busy,
    input  logic [NREG-1:0]   pend,
    output logic              in_ready,
    output logic              issue_fire,
    output fu_idx_t           issue_fu
);

    logic unit_found;

    always_comb begin
        unit_found = 1'b0;
        issue_fu   = '0;
        for (int i = 0; i < NUM_FU; i++) begin
            if (!unit_found && (unit_class(i) == cls) && !busy[i]) begin
                unit_found = 1'b1;
                issue_fu   = fu_idx_t'(i);
            end
        end
    end

    assign in_ready   = unit_found && !pend[dst];
    assign issue_fire = in_valid && in_ready;

endmodule

// File: rtl/sb_fu_entry.sv
module sb_fu_entry
    import sb_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        issue_en,
    input  instr_regs_t regs,
    input  tag_t        src1_tag,
    input  tag_t        src2_tag,
    input  logic        wb_fire,
    input  fu_idx_t     wb_fu,
    input  logic        done,
    output fu_view_t    view,
    output logic        read_grant
);

    localparam fu_idx_t MY_IDX = fu_idx_t'(IDX);

    fu_entry_t e;
    logic      my_wb;
    logic      j_wakes;
    logic      k_wakes;

    assign my_wb      = wb_fire && (wb_fu == MY_IDX);
    assign read_grant = (e.stage == ST_WAIT) && e.rj && e.rk;
    assign j_wakes    = e.qj.vld && wb_fire && (e.qj.fu == wb_fu);
    assign k_wakes    = e.qk.vld && wb_fire && (e.qk.fu == wb_fu);

    always_ff @(posedge clk) begin
        if (rst) begin
            e <= '0;
        end else if (issue_en) begin
            e.stage <= ST_WAIT;
            e.fi    <= regs.dst;
            e.fj    <= regs.src1;
            e.fk    <= regs.src2;
            e.qj    <= src1_tag;
            e.qk    <= src2_tag;
            e.rj    <= !src1_tag.vld;
            e.rk    <= !src2_tag.vld;
        end else begin
            case (e.stage)
                ST_WAIT: begin
                    if (read_grant) begin
                        e.stage <= ST_EXEC;
                        e.rj    <= 1'b0;
                        e.rk    <= 1'b0;
                    end else begin
                        if (j_wakes) begin
                            e.qj.vld <= 1'b0;
                            e.rj     <= 1'b1;
                        end
                        if (k_wakes) begin
                            e.qk.vld <= 1'b0;
                            e.rk     <= 1'b1;
                        end
                    end
                end
                ST_EXEC: if (done)  e.stage <= ST_DONE;
                ST_DONE: if (my_wb) e.stage <= ST_IDLE;
                default: ;
            endcase
        end
    end

    assign view.stage = e.stage;
    assign view.fi    = e.fi;
    assign view.fj    = e.fj;
    assign view.fk    = e.fk;
    assign view.rj    = e.rj;
    assign view.rk    = e.rk;

    // R6: one operand read per instruction
    assert_read_once_R6: assert property (@(posedge clk) disable iff (rst)
        read_grant |=> !read_grant);

    // R7: write-back only after the completion pulse moved the unit on
    assert_wb_after_done_R7: assert property (@(posedge clk) disable iff (rst)
        my_wb |-> (e.stage == ST_DONE));

    // R10: a granted unit is free in the next cycle
    assert_wb_frees_R10: assert property (@(posedge clk) disable iff (rst)
        my_wb |=> (e.stage == ST_IDLE));

endmodule

// File: rtl/sb_wb_arb.sv
module sb_wb_arb
    import sb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  fu_view_t          view [NUM_FU],
    output logic              wb_fire,
    output fu_idx_t           wb_fu,
    output logic [NUM_FU-1:0] wb_grant,
    output reg_idx_t          wb_dst
);

    logic [NUM_FU-1:0] war_clear;
    logic [NUM_FU-1:0] eligible;

    // a finished unit may write only when no waiting reader still needs the old value
    always_comb begin
        for (int f = 0; f < NUM_FU; f++) begin
            war_clear[f] = 1'b1;
            for (int g = 0; g < NUM_FU; g++) begin
                if (g != f && view[g].stage == ST_WAIT) begin
                    if ((view[g].rj && view[g].fj == view[f].fi) ||
                        (view[g].rk && view[g].fk == view[f].fi))
                        war_clear[f] = 1'b0;
                end
            end
            eligible[f] = (view[f].stage == ST_DONE) && war_clear[f];
        end
    end

    always_comb begin
        wb_fire  = 1'b0;
        wb_fu    = '0;
        wb_grant = '0;
        wb_dst   = '0;
        for (int f = 0; f < NUM_FU; f++) begin
            if (!wb_fire && eligible[f]) begin
                wb_fire     = 1'b1;
                wb_fu       = fu_idx_t'(f);
                wb_grant[f] = 1'b1;
                wb_dst      = view[f].fi;
            end
        end
    end

    // R9: a single write-back per cycle
    assert_one_wb_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wb_grant));

endmodule

// File: rtl/sb_hazard_ctl.sv
module sb_hazard_ctl
    import sb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_cls,
    input  logic [REG_W-1:0]  in_dst,
    input  logic [REG_W-1:0]  in_src1,
    input  logic [REG_W-1:0]  in_src2,
    output logic [FU_W-1:0]   issue_fu,
    output logic [NUM_FU-1:0] read_grant,
    input  logic [NUM_FU-1:0] fu_done,
    output logic [NUM_FU-1:0] wb_grant,
    output logic [REG_W-1:0]  wb_dst
);

    tag_t              rt [NREG];
    logic [NREG-1:0]   pend;
    logic [NUM_FU-1:0] busy;
    fu_view_t          view [NUM_FU];
    logic              issue_fire;
    fu_idx_t           alloc_fu;
    logic              wb_fire;
    fu_idx_t           wb_fu;
    reg_idx_t          wb_reg;
    instr_regs_t       regs;
    tag_t              tag1;
    tag_t              tag2;

    assign regs.dst  = in_dst;
    assign regs.src1 = in_src1;
    assign regs.src2 = in_src2;

    assign tag1 = resolve_tag(rt[in_src1], wb_fire, wb_fu);
    assign tag2 = resolve_tag(rt[in_src2], wb_fire, wb_fu);

    always_comb begin
        for (int r = 0; r < NREG; r++) pend[r] = rt[r].vld;
    end

    sb_issue_ctl u_issue (
        .in_valid   (in_valid),
        .cls        (op_cls_e'(in_cls)),
        .dst        (in_dst),
        .busy       (busy),
        .pend       (pend),
        .in_ready   (in_ready),
        .issue_fire (issue_fire),
        .issue_fu   (alloc_fu)
    );

    generate
        for (genvar i = 0; i < NUM_FU; i++) begin : g_unit
            sb_fu_entry #(.IDX(i)) u_entry (
                .clk        (clk),
                .rst        (rst),
                .issue_en   (issue_fire && (alloc_fu == fu_idx_t'(i))),
                .regs       (regs),
                .src1_tag   (tag1),
                .src2_tag   (tag2),
                .wb_fire    (wb_fire),
                .wb_fu      (wb_fu),
                .done       (fu_done[i]),
                .view       (view[i]),
                .read_grant (read_grant[i])
            );
            assign busy[i] = (view[i].stage != ST_IDLE);
        end
    endgenerate

    sb_wb_arb u_arb (
        .clk      (clk),
        .rst      (rst),
        .view     (view),
        .wb_fire  (wb_fire),
        .wb_fu    (wb_fu),
        .wb_grant (wb_grant),
        .wb_dst   (wb_reg)
    );

    // register-result table
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NREG; r++) rt[r] <= '0;
        end else begin
            if (wb_fire && rt[wb_reg].vld && rt[wb_reg].fu == wb_fu)
                rt[wb_reg].vld <= 1'b0;
            if (issue_fire) begin
                rt[in_dst].vld <= 1'b1;
                rt[in_dst].fu  <= alloc_fu;
            end
        end
    end

    assign issue_fu = alloc_fu;
    assign wb_dst   = wb_reg;

    // R3: an accepted instruction never targets a pending register
    assert_no_waw_R3: assert property (@(posedge clk) disable iff (rst)
        issue_fire |-> !rt[in_dst].vld);

    // R2: the allocated unit was free
    assert_unit_free_R2: assert property (@(posedge clk) disable iff (rst)
        issue_fire |-> !busy[alloc_fu]);

    // R4: the accepted instruction now owns its destination
    assert_owner_R4: assert property (@(posedge clk) disable iff (rst)
        issue_fire |=> (rt[$past(in_dst)].vld && rt[$past(in_dst)].fu == $past(alloc_fu)));

    // R10: write-back clears the pending destination
    assert_release_R10: assert property (@(posedge clk) disable iff (rst)
        (wb_fire && !issue_fire) |=> !rt[$past(wb_reg)].vld);

endmodule

// File: tb/sb_hazard_ctl_tb_top.sv
module sb_hazard_ctl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NFU        = 5;
    localparam int WATCHDOG   = 20000;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic           in_ready;
    logic [1:0]     in_cls = 2'd0;
    logic [3:0]     in_dst = '0;
    logic [3:0]     in_src1 = '0;
    logic [3:0]     in_src2 = '0;
    logic [2:0]     issue_fu;
    logic [NFU-1:0] read_grant;
    logic [NFU-1:0] fu_done = '0;
    logic [NFU-1:0] wb_grant;
    logic [3:0]     wb_dst;

    int cyc = 0;
    int tests = 0;
    int fails = 0;
    int rd_cyc [NFU];
    int wb_cyc [NFU];
    int timer  [NFU];
    int exp_q [$];
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sb_hazard_ctl dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_cls(in_cls), .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
        .issue_fu(issue_fu), .read_grant(read_grant), .fu_done(fu_done),
        .wb_grant(wb_grant), .wb_dst(wb_dst)
    );

    function automatic int unit_lat(input int u);
        case (u)
            0, 1:    return 2;
            2, 3:    return 4;
            default: return 10;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // functional-unit models and write-back monitor
    initial begin
        for (int u = 0; u < NFU; u++) begin
            timer[u] = 0; rd_cyc[u] = -1; wb_cyc[u] = -1;
        end
        forever begin
            @(negedge clk);
            if (!rst) begin
                for (int u = 0; u < NFU; u++) begin
                    fu_done[u] = (timer[u] == 1);
                    if (timer[u] > 0) timer[u]--;
                    if (read_grant[u]) begin
                        timer[u]  = unit_lat(u);
                        rd_cyc[u] = cyc;
                    end
                    if (wb_grant[u]) begin
                        wb_cyc[u] = cyc;
                        if (exp_q.size() == 0) begin
                            chk("R9 unexpected write-back", 1, 0);
                        end else begin
                            chk("R9 write-back order", int'(wb_dst), exp_q.pop_front());
                        end
                    end
                end
            end
        end
    end

    task automatic issue_op(input int cls, input int dst, input int s1, input int s2,
                            output int at, output int fu);
        @(negedge clk);
        in_valid = 1'b1; in_cls = 2'(cls); in_dst = 4'(dst);
        in_src1 = 4'(s1); in_src2 = 4'(s2);
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        at = cyc;
        fu = int'(issue_fu);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (30) @(negedge clk);
        chk("R9 queue drained", exp_q.size(), 0);
    endtask

    initial begin
        int c0, c1, c2, f0, f1, f2;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        #1;
        // R1: reset state
        chk("R1 read_grant", int'(read_grant), 0);
        chk("R1 wb_grant", int'(wb_grant), 0);
        chk("R1 in_ready", int'(in_ready), 1);

        // R6 R7 R4: independent integer op
        exp_q.push_back(1);
        issue_op(0, 1, 2, 3, c0, f0);
        chk("R4 int unit", f0, 0);
        drain();
        chk("R6 read next cycle", rd_cyc[0], c0 + 1);
        chk("R7 wb after done", wb_cyc[0], c0 + 4);

        // R5: RAW on a long divide
        exp_q.push_back(4); exp_q.push_back(5);
        issue_op(3, 4, 2, 3, c0, f0);
        issue_op(1, 5, 4, 1, c1, f1);
        drain();
        chk("R4 div unit", f0, 4);
        chk("R5 divide wb", wb_cyc[4], c0 + 12);
        chk("R5 read after producer", rd_cyc[1], c0 + 13);
        chk("R7 add wb", wb_cyc[1], c0 + 16);

        // R8: WAR hold of a finished add
        exp_q.push_back(6); exp_q.push_back(8); exp_q.push_back(7);
        issue_op(3, 6, 2, 3, c0, f0);
        issue_op(2, 7, 6, 8, c1, f1);
        issue_op(1, 8, 2, 3, c2, f2);
        drain();
        chk("R5 mul reads after div", rd_cyc[2], c0 + 13);
        chk("R8 add held until mul read", wb_cyc[1], c0 + 14);
        chk("R7 mul wb", wb_cyc[2], c0 + 18);

        // R3 R10: WAW stall and release
        exp_q.push_back(9); exp_q.push_back(9);
        issue_op(3, 9, 2, 3, c0, f0);
        issue_op(0, 9, 1, 1, c1, f1);
        drain();
        chk("R3 waw stall", c1, c0 + 13);
        chk("R10 issue after wb", c1, wb_cyc[4] + 1);

        // R2 R4: multiplier allocation and structural stall
        exp_q.push_back(10); exp_q.push_back(11); exp_q.push_back(12);
        issue_op(2, 10, 1, 1, c0, f0);
        issue_op(2, 11, 1, 1, c1, f1);
        issue_op(2, 12, 1, 1, c2, f2);
        chk("R4 first mul", f0, 2);
        chk("R4 second mul", f1, 3);
        chk("R2 third mul reuses", f2, 2);
        chk("R2 structural stall", c2, c0 + 7);
        drain();

        // R9: simultaneous completions, lowest index first
        exp_q.push_back(13); exp_q.push_back(14); exp_q.push_back(15);
        issue_op(3, 13, 2, 3, c0, f0);
        issue_op(0, 14, 13, 1, c1, f1);
        issue_op(1, 15, 13, 1, c2, f2);
        drain();
        chk("R5 both read", rd_cyc[1], rd_cyc[0]);
        chk("R9 int first", wb_cyc[0], c0 + 16);
        chk("R9 add next", wb_cyc[1], c0 + 17);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule